// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar as packed BCD bytes: seconds, minutes, hours, day of week, date, month and a two-digit year. A free-running prescaler counts enable pulses from a 32.768 kHz reference and emits a one-second tick. Each tick advances the seconds, and carries ripple upward through minutes, hours, weekday, date, month and year.

The hours byte carries its own format. One bit picks between a 24-hour count and a 12-hour count with an AM/PM flag. Software sets any field through a single-byte write port. A write also restarts the prescaler, so the second that follows it is a full second long. A combinational read port returns any field by index. The length of each month, February in leap years included, is worked out directly from the BCD month and year bytes.

Top module: `bcdTimeKeeper`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00 (24-hour mode), weekday 01, date 01, month 01 and year 00. Index 7 always reads 00.
- R2: A tick occurs on the clock edge at which the PRESCALE_DIV-th counted `refEn` pulse since the last restart is sampled. The register update lands on that same edge.
- R3: Seconds (index 0) and minutes (index 1) count 00 to 59 in BCD. Each wraps from 59 to 00 and carries into the next field.
- R4: When hours (index 2) bit 6 is 0, bits 5:0 hold a BCD hour from 00 to 23. The step after 23 is 00 and advances the day.
- R5: When hours bit 6 is 1, bit 5 is PM (1 = PM) and bits 4:0 hold 01 to 12. Stepping 11 to 12 flips PM, 12 steps to 01, and the day advances only when 11 PM becomes 12 AM.
- R6: The weekday (index 3) counts 01 to 07 and then returns to 01 on each day advance.
- R7: The date (index 4) wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except 02. The month (index 5) wraps from 12 to 01 and carries into the year (index 6), which wraps from 99 to 00.
- R8: In month 02 the last day is 29 when the BCD year is a multiple of 4, and 28 otherwise.
- R9: A write stores only the used bits. The masks are 7F for seconds, minutes and hours, 07 for weekday, 3F for date, 1F for month and FF for year. A write to index 7 changes nothing and does not restart the prescaler.
- R10: A write to indices 0 to 6 clears the prescaler. If it falls on a cycle that would have ticked, the tick is dropped and nothing advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refEn | input | 1 | One-cycle pulse per 32.768 kHz reference period |
| wrEn | input | 1 | Field write strobe |
| wrAddr | input | 3 | Field index for a write |
| wrData | input | 8 | BCD byte to write |
| rdAddr | input | 3 | Field index for a read |
| rdData | output | 8 | Selected field, combinational |

## Verification
The range assertions assume that software writes only legal BCD values within each field's range. A wrapping comparison against an out-of-range value would otherwise never fire. The stimulus therefore writes only legal times and dates, except for bits that the masks strip away. The assertion that a write suppresses the next tick assumes PRESCALE_DIV is at least 2. A behavioural model in integer arithmetic tracks every cycle, while directed runs place month ends, leap Februaries, both hour formats and a write on a tick edge.

// File: rtl/tkPkg.sv
package tkPkg;
  localparam int NUM_FIELDS = 7;
  localparam int FIELD_AW   = 3;

  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DOW  = 3;
  localparam int IDX_DATE = 4;
  localparam int IDX_MON  = 5;
  localparam int IDX_YEAR = 6;

  typedef struct packed {
    logic                  tick;
    logic [NUM_FIELDS-1:0] wrSel;
  } tkStrobe_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] fieldMask(input int idx);
    case (idx)
      IDX_DOW:  return 8'h07;
      IDX_DATE: return 8'h3F;
      IDX_MON:  return 8'h1F;
      IDX_YEAR: return 8'hFF;
      default:  return 8'h7F;
    endcase
  endfunction

  function automatic logic [7:0] resetValue(input int idx);
    case (idx)
      IDX_DOW, IDX_DATE, IDX_MON: return 8'h01;
      default:                    return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/tkControl.sv
module tkControl
  import tkPkg::*;
#(
  parameter int PRESCALE_DIV = 32768
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                refEn,
  input  logic                wrEn,
  input  logic [FIELD_AW-1:0] wrAddr,
  output tkStrobe_t           strobe
);
  localparam int CNT_W = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PRESCALE_DIV - 1);

  logic [CNT_W-1:0]      preCnt;
  logic [NUM_FIELDS-1:0] wrSel;
  logic                  anyWr;
  logic                  wouldTick;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
    assign wrSel[i] = wrEn && (wrAddr == FIELD_AW'(i));
  end

  assign anyWr     = |wrSel;
  assign wouldTick = refEn && (preCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN)          preCnt <= '0;
    else if (anyWr)     preCnt <= '0;
    else if (wouldTick) preCnt <= '0;
    else if (refEn)     preCnt <= preCnt + CNT_W'(1);
  end

  assign strobe.tick  = wouldTick && !anyWr;
  assign strobe.wrSel = wrSel;

  a_r2_tick_needs_ref: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tick |-> refEn);

  a_r10_write_kills_tick: assert property (@(posedge clk) disable iff (!rstN)
    wrSel != '0 |-> !strobe.tick);

  if (PRESCALE_DIV >= 2) begin : g_restart
    a_r10_write_restarts: assert property (@(posedge clk) disable iff (!rstN)
      anyWr |=> !strobe.tick);
  end
endmodule

// File: rtl/tkDatapath.sv
module tkDatapath
  import tkPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  tkStrobe_t           strobe,
  input  logic [7:0]          wrData,
  input  logic [FIELD_AW-1:0] rdAddr,
  output logic [7:0]          rdData
);
  logic [7:0] fieldR   [NUM_FIELDS];
  logic [7:0] tickNext [NUM_FIELDS];

  logic [7:0] secR, minR, hourR, dowR, dateR, monR, yearR;
  assign secR  = fieldR[IDX_SEC];
  assign minR  = fieldR[IDX_MIN];
  assign hourR = fieldR[IDX_HOUR];
  assign dowR  = fieldR[IDX_DOW];
  assign dateR = fieldR[IDX_DATE];
  assign monR  = fieldR[IDX_MON];
  assign yearR = fieldR[IDX_YEAR];

  logic       minStep, hourStep, dayStep, monStep, yearStep;
  logic       hourCarry, isLeap;
  logic [4:0] leapSum;
  logic [7:0] lastDay, hourNext;

  // leap when (10*tens + units) mod 4 == 0, i.e. (units + 2*tens[0]) mod 4 == 0
  assign leapSum = {1'b0, yearR[3:0]} + {3'b000, yearR[4], 1'b0};
  assign isLeap  = (leapSum[1:0] == 2'b00);

  always_comb begin
    if (monR == 8'h02)
      lastDay = isLeap ? 8'h29 : 8'h28;
    else if (monR == 8'h04 || monR == 8'h06 || monR == 8'h09 || monR == 8'h11)
      lastDay = 8'h30;
    else
      lastDay = 8'h31;
  end

  always_comb begin
    hourCarry = 1'b0;
    if (hourR[6]) begin
      if (hourR[4:0] == 5'h11) begin
        hourNext  = {2'b01, ~hourR[5], 5'h12};
        hourCarry = hourR[5];
      end else if (hourR[4:0] == 5'h12) begin
        hourNext = {2'b01, hourR[5], 5'h01};
      end else begin
        hourNext = {2'b01, hourR[5], 5'(bcdInc({3'b000, hourR[4:0]}))};
      end
    end else begin
      if (hourR[5:0] == 6'h23) begin
        hourNext  = 8'h00;
        hourCarry = 1'b1;
      end else begin
        hourNext = bcdInc({2'b00, hourR[5:0]});
      end
    end
  end

  assign minStep  = (secR == 8'h59);
  assign hourStep = minStep && (minR == 8'h59);
  assign dayStep  = hourStep && hourCarry;
  assign monStep  = dayStep && (dateR == lastDay);
  assign yearStep = monStep && (monR == 8'h12);

  always_comb begin
    tickNext[IDX_SEC]  = minStep ? 8'h00 : bcdInc(secR);
    tickNext[IDX_MIN]  = !minStep ? minR : (hourStep ? 8'h00 : bcdInc(minR));
    tickNext[IDX_HOUR] = hourStep ? hourNext : hourR;
    tickNext[IDX_DOW]  = !dayStep ? dowR : ((dowR == 8'h07) ? 8'h01 : bcdInc(dowR));
    tickNext[IDX_DATE] = !dayStep ? dateR : (monStep ? 8'h01 : bcdInc(dateR));
    tickNext[IDX_MON]  = !monStep ? monR : (yearStep ? 8'h01 : bcdInc(monR));
    tickNext[IDX_YEAR] = !yearStep ? yearR : ((yearR == 8'h99) ? 8'h00 : bcdInc(yearR));
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rstN)                fieldR[i] <= resetValue(i);
      else if (strobe.wrSel[i]) fieldR[i] <= wrData & fieldMask(i);
      else if (strobe.tick)     fieldR[i] <= tickNext[i];
    end
  end

  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (rdAddr == FIELD_AW'(i)) rdData = fieldR[i];
  end

  a_r3_sec_legal: assert property (@(posedge clk) disable iff (!rstN)
    secR[3:0] <= 4'd9 && secR <= 8'h59);

  a_r3_sec_wraps: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && secR == 8'h59) |=> secR == 8'h00);

  a_r4_hour24_legal: assert property (@(posedge clk) disable iff (!rstN)
    !hourR[6] |-> (hourR[5:0] <= 6'h23 && hourR[3:0] <= 4'd9));

  a_r5_hour12_legal: assert property (@(posedge clk) disable iff (!rstN)
    hourR[6] |-> (hourR[4:0] != 5'h00 && hourR[4:0] <= 5'h12));

  a_r6_dow_legal: assert property (@(posedge clk) disable iff (!rstN)
    dowR != 8'h00 && dowR <= 8'h07);

  a_r8_feb_end: assert property (@(posedge clk) disable iff (!rstN)
    (monR == 8'h02 && dateR == 8'h29 && strobe.tick && dayStep) |=> dateR == 8'h01);

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && strobe.wrSel == '0) |=> $stable(secR) && $stable(dateR));
endmodule

// File: rtl/bcdTimeKeeper.sv
module bcdTimeKeeper
  import tkPkg::*;
#(
  parameter int PRESCALE_DIV = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refEn,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [2:0] rdAddr,
  output logic [7:0] rdData
);
  tkStrobe_t strobe;

  tkControl #(.PRESCALE_DIV(PRESCALE_DIV)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .refEn  (refEn),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .strobe (strobe)
  );

  tkDatapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );
endmodule

// File: tb/tb_bcdTimeKeeper.sv
module tb_bcdTimeKeeper;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       refEn;
  logic       refGate = 1'b0;
  logic       refMode = 1'b0;
  logic       rotate = 1'b0;
  logic [2:0] holdAddr = '0;
  logic [15:0] lfsr = 16'hACE1;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign refEn = refGate & (refMode ? lfsr[0] : 1'b1);

  bcdTimeKeeper #(.PRESCALE_DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .refEn(refEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  always @(posedge clk) rdAddr <= rotate ? rdAddr + 3'd1 : holdAddr;

  // behavioural reference in plain integers
  int ms, mm, mh, mpm, m12, mdow, mdt, mmo, myr, mcnt;

  function automatic int toB(int v); return ((v / 10) << 4) | (v % 10); endfunction
  function automatic int fromB(int b); return (b >> 4) * 10 + (b & 15); endfunction

  function automatic int monthLen(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] modelReg(int a);
    case (a)
      0: return 8'(toB(ms));
      1: return 8'(toB(mm));
      2: return m12 ? 8'(64 + 32 * mpm + toB(mh)) : 8'(toB(mh));
      3: return 8'(mdow);
      4: return 8'(toB(mdt));
      5: return 8'(toB(mmo));
      6: return 8'(toB(myr));
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tagOf(int a);
    case (a)
      0, 1: return "R3";
      2: return "R4/R5";
      3: return "R6";
      4, 5, 6: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic modelAdvance();
    ms++;
    if (ms < 60) return;
    ms = 0; mm++;
    if (mm < 60) return;
    mm = 0;
    if (m12) begin
      if (mh == 11) begin
        mh = 12; mpm ^= 1;
        if (mpm != 0) return;
      end else begin
        mh = (mh == 12) ? 1 : mh + 1;
        return;
      end
    end else begin
      if (mh < 23) begin mh++; return; end
      mh = 0;
    end
    mdow = (mdow == 7) ? 1 : mdow + 1;
    if (mdt < monthLen(mmo, myr)) begin mdt++; return; end
    mdt = 1;
    if (mmo < 12) begin mmo++; return; end
    mmo = 1;
    myr = (myr == 99) ? 0 : myr + 1;
  endtask

  task automatic modelWrite(int a, int d);
    case (a)
      0: ms = fromB(d & 8'h7F);
      1: mm = fromB(d & 8'h7F);
      2: begin
        m12 = (d >> 6) & 1;
        if (m12 != 0) begin mpm = (d >> 5) & 1; mh = fromB(d & 8'h1F); end
        else begin mpm = 0; mh = fromB(d & 8'h3F); end
      end
      3: mdow = d & 8'h07;
      4: mdt = fromB(d & 8'h3F);
      5: mmo = fromB(d & 8'h1F);
      6: myr = fromB(d);
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      ms = 0; mm = 0; mh = 0; mpm = 0; m12 = 0; mdow = 1; mdt = 1; mmo = 1; myr = 0; mcnt = 0;
    end else if (wrEn && wrAddr < 3'd7) begin
      modelWrite(int'(wrAddr), int'(wrData));
      mcnt = 0;
    end else if (refEn) begin
      if (mcnt == DIV - 1) begin mcnt = 0; modelAdvance(); end
      else mcnt++;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison against the reference (R2 timing, all fields)
  always @(negedge clk) if (rstN && !done) chk(tagOf(int'(rdAddr)), rdData, modelReg(int'(rdAddr)));

  task automatic peek(int a, logic [7:0] exp, string tag);
    holdAddr = 3'(a);
    @(negedge clk);
    chk(tag, rdData, exp);
  endtask

  task automatic wr(int a, logic [7:0] d);
    wrEn = 1'b1; wrAddr = 3'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runRef(int n);
    refGate = 1'b1;
    repeat (n) @(negedge clk);
    refGate = 1'b0;
  endtask

  task automatic setAll(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] dw,
                        logic [7:0] dt, logic [7:0] mo, logic [7:0] yr);
    wr(0, s); wr(1, m); wr(2, h); wr(3, dw); wr(4, dt); wr(5, mo); wr(6, yr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    peek(0, 8'h00, "R1"); peek(1, 8'h00, "R1"); peek(2, 8'h00, "R1");
    peek(3, 8'h01, "R1"); peek(4, 8'h01, "R1"); peek(5, 8'h01, "R1");
    peek(6, 8'h00, "R1"); peek(7, 8'h00, "R1");

    // R2: exactly DIV pulses per tick
    runRef(DIV - 1); peek(0, 8'h00, "R2");
    runRef(1);       peek(0, 8'h01, "R2");

    // R3 R4 R6 R7: full cascade from the end of year 99, 24-hour
    setAll(8'h58, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    runRef(2 * DIV);
    peek(0, 8'h00, "R3"); peek(1, 8'h00, "R3"); peek(2, 8'h00, "R4");
    peek(3, 8'h01, "R6"); peek(4, 8'h01, "R7"); peek(5, 8'h01, "R7");
    peek(6, 8'h00, "R7");

    // R5: 11 PM -> 12 AM advances the day
    setAll(8'h59, 8'h59, 8'h71, 8'h03, 8'h15, 8'h05, 8'h10);
    runRef(DIV);
    peek(2, 8'h52, "R5"); peek(3, 8'h04, "R5"); peek(4, 8'h16, "R5");
    // R5: 12 -> 01, PM kept
    wr(0, 8'h59); wr(1, 8'h59); wr(2, 8'h72);
    runRef(DIV);
    peek(2, 8'h61, "R5"); peek(4, 8'h16, "R5");
    // R5: 11 AM -> 12 PM, no day change
    wr(0, 8'h59); wr(1, 8'h59); wr(2, 8'h51);
    runRef(DIV);
    peek(2, 8'h72, "R5"); peek(4, 8'h16, "R5");

    // R8 leap years
    setAll(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    runRef(DIV);
    peek(4, 8'h29, "R8"); peek(5, 8'h02, "R8");
    wr(0, 8'h59); wr(1, 8'h59); wr(2, 8'h23);
    runRef(DIV);
    peek(4, 8'h01, "R8"); peek(5, 8'h03, "R8");
    setAll(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
    runRef(DIV);
    peek(4, 8'h01, "R8"); peek(5, 8'h03, "R8");
    setAll(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00);
    runRef(DIV);
    peek(4, 8'h29, "R8");

    // R7 thirty-day month
    setAll(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h11, 8'h45);
    runRef(DIV);
    peek(4, 8'h01, "R7"); peek(5, 8'h12, "R7");

    // R9 masking and the dead index
    wr(4, 8'hD5); wr(3, 8'hFA); wr(5, 8'hE9);
    peek(4, 8'h15, "R9"); peek(3, 8'h02, "R9"); peek(5, 8'h09, "R9");
    wr(0, 8'h30);
    runRef(3);
    wr(7, 8'hAA);
    peek(7, 8'h00, "R9"); peek(0, 8'h30, "R9");
    runRef(DIV - 3); peek(0, 8'h31, "R9");

    // R10 a write restarts the prescaler
    wr(0, 8'h40);
    runRef(5);
    wr(1, 8'h22);
    runRef(DIV - 1); peek(0, 8'h40, "R10");
    runRef(1);       peek(0, 8'h41, "R10");
    // R10 write on the tick edge drops the tick
    runRef(DIV - 1);
    refGate = 1'b1; wrEn = 1'b1; wrAddr = 3'd1; wrData = 8'h10;
    @(negedge clk);
    refGate = 1'b0; wrEn = 1'b0;
    peek(0, 8'h41, "R10"); peek(1, 8'h10, "R10");
    runRef(DIV - 1); peek(0, 8'h41, "R10");
    runRef(1);       peek(0, 8'h42, "R10");

    // irregular reference pulses, model compared every cycle (R2)
    rotate = 1'b1; refMode = 1'b1;
    setAll(8'h00, 8'h58, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    runRef(3000);
    setAll(8'h10, 8'h59, 8'h71, 8'h05, 8'h28, 8'h02, 8'h04);
    runRef(3000);
    rotate = 1'b0;
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule